// File: doc/BRIEF.md
# Dual-Space SPI Register Slave

This block is the serial front end of a peripheral whose registers are split into two address spaces. A narrow space of 64 registers is reached with a single command byte. A wide space of 1024 registers is reached with a two-byte command. The block runs entirely on the system clock. It samples SCLK, MOSI and the active-low chip select through synchronisers and detects the SCLK edges. It then assembles the command, tells a read from a write, and drives a single-cycle register port toward the core behind it.

The bus runs in SPI mode 0 and shifts the most significant bit first. Once the address is known, a transfer may continue for as long as chip select stays low. Every further byte goes to, or comes from, the next address in the same space. A long read can therefore drain a buffer region and the bytes that follow it in one transaction. A write reaches the core only after all eight bits of a data byte have arrived. A read is fetched ahead of time: the core sees the first read strobe on the last address bit, and each later strobe at the end of the previous data byte. This way the byte is ready before the SCLK falling edge that must present it.

Top module: `spi_dual_slave`

## Requirements
- R1: After reset, reg_we_o and reg_re_o are 0, reg_addr_o is 0 and miso_o is 0.
- R2: Short write. The command byte has bit 7 = 0, bits 6:1 = address and bit 0 = 1. The following data byte produces exactly one reg_we_o pulse with that address, reg_long_o = 0 and reg_wdata_o = the byte. No read strobe occurs.
- R3: Long write. The 16-bit command has bit 15 = 1, bits 14:5 = address, bit 4 = 1 for a write, and bits 3:0 ignored. The data byte produces one reg_we_o pulse with that address and reg_long_o = 1.
- R4: In a write burst, each further data byte is written to the next address. The short space wraps from 0x3F to 0x00 and the long space from 0x3FF to 0x000. In the cycle after each write pulse, reg_addr_o shows the incremented address.
- R5: Read. A command whose write bit is 0 raises reg_re_o with the command address as soon as the last address bit is sampled. reg_rdata_i is captured in that same cycle. The byte is shifted out on miso_o MSB first, changing after SCLK falling edges, so that it is valid on the eight rising edges after the address.
- R6: In a read burst, each data byte that completes triggers a read strobe at the next address in the same space, with the same wrap as R4. Successive MISO bytes come from consecutive addresses.
- R7: Raising cs_ni discards any partial byte, in either the command or the data phase, without a strobe. The next transaction starts in the command phase.
- R8: During the data phase of a read, MOSI is ignored and no write strobe is produced.
- R9: reg_we_o and reg_re_o are never high together, and each is a single-cycle pulse.
- R10: While cs_ni is high, miso_o is driven 0 once the synchroniser has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock (mode 0) |
| mosi_i | input | 1 | Serial data from master |
| cs_ni | input | 1 | Active-low chip select |
| miso_o | output | 1 | Serial data to master |
| reg_addr_o | output | 10 | Register address (short space uses bits 5:0) |
| reg_long_o | output | 1 | 1 = long space, 0 = short space |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Read data, valid in the cycle of reg_re_o |

## Verification
The bench sweeps every short address for single writes and reads, and a spread of long addresses that includes the buffer base and the top of the space. A design that swapped the address field boundaries or misread the write bit would show up on every such transaction. Bursts begin at 0x3E and 0x3FE, so an address counter that failed to wrap, or wrapped the short space at the long limit, would write to or read from the wrong register. Chip select is raised partway through a data byte and partway through a command. A design that kept its bit count would then issue a stray strobe or misalign the next command. A read with MOSI held high catches a decoder that still treats data-phase bits as writes.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHORT_AW = BYTE_W - 2;
  localparam int LONG_AW  = 10;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int HI_W     = BYTE_W - 1;
  localparam int LO_W     = LONG_AW - HI_W;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_LADR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  function automatic logic [LONG_AW-1:0] step_addr(input logic [LONG_AW-1:0] a,
                                                   input logic is_long);
    logic [LONG_AW-1:0] n;
    n = a + 1'b1;
    if (!is_long) n[LONG_AW-1:SHORT_AW] = '0;
    return n;
  endfunction
endpackage

// File: rtl/spi_dual_sync.sv
module spi_dual_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic mosi_o,
  output logic active_o
);
  logic [STAGES-1:0] sclk_q, mosi_q, cs_q;
  logic              sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
      sclk_d <= 1'b0;
    end else begin
      sclk_q[0] <= sclk_i;
      mosi_q[0] <= mosi_i;
      cs_q[0]   <= cs_ni;
      for (int i = 1; i < STAGES; i++) begin
        sclk_q[i] <= sclk_q[i-1];
        mosi_q[i] <= mosi_q[i-1];
        cs_q[i]   <= cs_q[i-1];
      end
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign active_o    = ~cs_q[STAGES-1];
  assign mosi_o      = mosi_q[STAGES-1];
  assign sclk_rise_o = active_o &  sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = active_o & ~sclk_q[STAGES-1] &  sclk_d;
endmodule

// File: rtl/spi_dual_decode.sv
module spi_dual_decode
  import spi_dual_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  input  logic               active_i,
  input  logic               mosi_i,
  output logic [LONG_AW-1:0] addr_o,
  output logic               long_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               re_o
);
  phase_e             phase_q;
  logic [CNT_W-1:0]   bit_q;
  logic [BYTE_W-2:0]  sr_q;
  logic [HI_W-1:0]    hi_q;
  logic               wr_q, long_q, we_q, re_q;
  logic [LONG_AW-1:0] addr_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic [BYTE_W-1:0]  byte_w;
  logic               byte_done;

  assign byte_w    = {sr_q, mosi_i};
  assign byte_done = rise_i && (bit_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      bit_q   <= '0;
      sr_q    <= '0;
      hi_q    <= '0;
      wr_q    <= 1'b0;
      long_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      // post-increment after a write strobe
      if (we_q) addr_q <= step_addr(addr_q, long_q);
      if (!active_i) begin
        phase_q <= PH_CMD;
        bit_q   <= '0;
      end else if (rise_i) begin
        sr_q  <= byte_w[BYTE_W-2:0];
        bit_q <= bit_q + 1'b1;
        if (byte_done) begin
          case (phase_q)
            PH_CMD: begin
              if (!byte_w[BYTE_W-1]) begin
                addr_q  <= LONG_AW'(byte_w[SHORT_AW:1]);
                long_q  <= 1'b0;
                wr_q    <= byte_w[0];
                re_q    <= ~byte_w[0];
                phase_q <= PH_DATA;
              end else begin
                hi_q    <= byte_w[HI_W-1:0];
                phase_q <= PH_LADR;
              end
            end
            PH_LADR: begin
              addr_q  <= {hi_q, byte_w[BYTE_W-1 -: LO_W]};
              long_q  <= 1'b1;
              wr_q    <= byte_w[BYTE_W-1-LO_W];
              re_q    <= ~byte_w[BYTE_W-1-LO_W];
              phase_q <= PH_DATA;
            end
            PH_DATA: begin
              if (wr_q) begin
                we_q    <= 1'b1;
                wdata_q <= byte_w;
              end else begin
                addr_q <= step_addr(addr_q, long_q);
                re_q   <= 1'b1;
              end
            end
            default: phase_q <= PH_CMD;
          endcase
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign long_o  = long_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign re_o    = re_q;
endmodule

// File: rtl/spi_dual_tx.sv
module spi_dual_tx
  import spi_dual_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              miso_o
);
  logic [BYTE_W-1:0] hold_q, sr_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sr_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (!active_i) begin
        sr_q   <= '0;
        pend_q <= 1'b0;
      end else if (fall_i) begin
        if (pend_q) begin
          sr_q   <= hold_q;
          pend_q <= 1'b0;
        end else begin
          sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
        end
      end
      if (load_i) begin
        hold_q <= rdata_i;
        pend_q <= 1'b1;
      end
    end
  end

  assign miso_o = sr_q[BYTE_W-1];
endmodule

// File: rtl/spi_dual_slave.sv
module spi_dual_slave
  import spi_dual_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               mosi_i,
  input  logic               cs_ni,
  output logic               miso_o,
  output logic [LONG_AW-1:0] reg_addr_o,
  output logic               reg_long_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i
);
  logic rise, fall, mosi_s, active;

  spi_dual_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .mosi_i      (mosi_i),
    .cs_ni       (cs_ni),
    .sclk_rise_o (rise),
    .sclk_fall_o (fall),
    .mosi_o      (mosi_s),
    .active_o    (active)
  );

  spi_dual_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .active_i (active),
    .mosi_i   (mosi_s),
    .addr_o   (reg_addr_o),
    .long_o   (reg_long_o),
    .wdata_o  (reg_wdata_o),
    .we_o     (reg_we_o),
    .re_o     (reg_re_o)
  );

  spi_dual_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .active_i (active),
    .load_i   (reg_re_o),
    .rdata_i  (reg_rdata_i),
    .miso_o   (miso_o)
  );
endmodule

// File: rtl/spi_dual_chk.sv
module spi_dual_chk
  import spi_dual_pkg::*;
#(
  parameter int STAGES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni,
  input logic               miso_o,
  input logic [LONG_AW-1:0] reg_addr_o,
  input logic               reg_long_o,
  input logic               reg_we_o,
  input logic               reg_re_o
);
  int unsigned cs_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_hi_cnt <= 0;
    else if (!cs_ni) cs_hi_cnt <= 0;
    else if (cs_hi_cnt < 255) cs_hi_cnt <= cs_hi_cnt + 1;
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  // R9
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R9
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_addr_o == ($past(reg_long_o)
                                 ? LONG_AW'($past(reg_addr_o) + 1'b1)
                                 : LONG_AW'(SHORT_AW'($past(reg_addr_o) + 1'b1))));
  // R2
  short_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_we_o || reg_re_o) && !reg_long_o) |-> reg_addr_o[LONG_AW-1:SHORT_AW] == '0);
  // R10
  idle_miso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_cnt > STAGES + 1) |-> !miso_o);
endmodule

bind spi_dual_slave spi_dual_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .miso_o     (miso_o),
  .reg_addr_o (reg_addr_o),
  .reg_long_o (reg_long_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o)
);

// File: tb/tb_spi_dual_slave.sv
`timescale 1ns/1ps
module tb_spi_dual_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [9:0] addr;
  logic lng, we, re;
  logic [7:0] wdata, rdata;

  always #4 clk = ~clk;

  spi_dual_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_ni(cs_n),
    .miso_o(miso), .reg_addr_o(addr), .reg_long_o(lng), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  function automatic logic [7:0] pat(input logic [9:0] a, input logic l);
    return 8'(a[7:0] * 8'd5 + {6'd0, a[9:8]} * 8'd3 + (l ? 8'hA5 : 8'h3C));
  endfunction

  assign rdata = pat(addr, lng);

  int checks = 0, fails = 0;
  int we_n, re_n, dbl;
  logic [9:0] we_a [16];
  logic       we_l [16];
  logic [7:0] we_d [16];
  logic [9:0] re_a [16];
  logic       re_l [16];
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic we_prev = 1'b0, re_prev = 1'b0;

  always @(negedge clk) begin
    if (we) begin
      if (we_n < 16) begin we_a[we_n] = addr; we_l[we_n] = lng; we_d[we_n] = wdata; end
      we_n++;
    end
    if (re) begin
      if (re_n < 16) begin re_a[re_n] = addr; re_l[re_n] = lng; end
      re_n++;
    end
    if ((we && we_prev) || (re && re_prev) || (we && re)) dbl++;
    we_prev = we;
    re_prev = re;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // cut < 0 sends all bytes
  task automatic spi_run(input int nbytes, input int cut);
    int total;
    total = (cut >= 0) ? cut : nbytes * 8;
    we_n = 0; re_n = 0;
    for (int k = 0; k < 16; k++) rx_b[k] = 8'h00;
    @(negedge clk);
    cs_n = 1'b0;
    mosi = tx_b[0][7];
    repeat (4) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      rx_b[i/8][7-(i%8)] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (i + 1 < total) mosi = tx_b[(i+1)/8][7-((i+1)%8)];
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] s_cmd(input logic [5:0] a, input logic w);
    return {1'b0, a, w};
  endfunction

  task automatic set_long(input logic [9:0] a, input logic w, input logic [3:0] nib);
    tx_b[0] = {1'b1, a[9:3]};
    tx_b[1] = {a[2:0], w, nib};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    dbl = 0; we_n = 0; re_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk(!miso && !we && !re, "R1 idle", {29'd0, miso, we, re}, 0);
    chk(addr == 10'd0, "R1 addr", int'(addr), 0);

    // R2 full short write sweep
    for (int a = 0; a < 64; a++) begin
      tx_b[0] = s_cmd(6'(a), 1'b1);
      tx_b[1] = 8'(a * 3 + 1);
      spi_run(2, -1);
      chk(we_n == 1 && re_n == 0, "R2 strobe count", we_n * 16 + re_n, 16);
      chk(we_a[0] == 10'(a) && !we_l[0] && we_d[0] == 8'(a * 3 + 1), "R2 write",
          {we_l[0], we_a[0], we_d[0]}, {1'b0, 10'(a), 8'(a * 3 + 1)});
    end

    // R3 long write sweep, nibble varies
    for (int a = 0; a < 1024; a += 31) begin
      set_long(10'(a), 1'b1, 4'(a));
      tx_b[2] = 8'(a ^ 8'h5A);
      spi_run(3, -1);
      chk(we_n == 1 && re_n == 0, "R3 strobe count", we_n * 16 + re_n, 16);
      chk(we_a[0] == 10'(a) && we_l[0] && we_d[0] == 8'(a ^ 8'h5A), "R3 write",
          {we_l[0], we_a[0], we_d[0]}, {1'b1, 10'(a), 8'(a ^ 8'h5A)});
    end
    foreach (tx_b[k]) tx_b[k] = 8'h00;
    set_long(10'h3FF, 1'b1, 4'hF);
    tx_b[2] = 8'h77;
    spi_run(3, -1);
    chk(we_n == 1 && we_a[0] == 10'h3FF && we_l[0], "R3 top", int'(we_a[0]), 'h3FF);

    // R4 short burst wrap
    tx_b[0] = s_cmd(6'h3E, 1'b1);
    for (int k = 0; k < 4; k++) tx_b[1+k] = 8'(8'hA0 + k);
    spi_run(5, -1);
    chk(we_n == 4, "R4 short burst count", we_n, 4);
    for (int k = 0; k < 4; k++)
      chk(we_a[k] == 10'((6'h3E + k) % 64) && we_d[k] == 8'(8'hA0 + k) && !we_l[k],
          "R4 short burst", int'(we_a[k]), (62 + k) % 64);
    // R4 long burst wrap
    set_long(10'h3FE, 1'b1, 4'h0);
    for (int k = 0; k < 3; k++) tx_b[2+k] = 8'(8'h10 + k);
    spi_run(5, -1);
    chk(we_n == 3, "R4 long burst count", we_n, 3);
    for (int k = 0; k < 3; k++)
      chk(we_a[k] == 10'((1022 + k) % 1024) && we_d[k] == 8'(8'h10 + k) && we_l[k],
          "R4 long burst", int'(we_a[k]), (1022 + k) % 1024);

    // R5 short read sweep, R8 MOSI high during data
    for (int a = 0; a < 64; a++) begin
      tx_b[0] = s_cmd(6'(a), 1'b0);
      tx_b[1] = 8'hFF;
      spi_run(2, -1);
      chk(rx_b[1] == pat(10'(a), 1'b0), "R5 short read", int'(rx_b[1]), int'(pat(10'(a), 1'b0)));
      chk(re_n == 2 && re_a[0] == 10'(a) && !re_l[0], "R5 read strobe", int'(re_a[0]), a);
      chk(we_n == 0, "R8 no write in read", we_n, 0);
    end
    // R5 long read sweep
    for (int a = 5; a < 1024; a += 37) begin
      set_long(10'(a), 1'b0, 4'(a));
      tx_b[2] = 8'h00;
      spi_run(3, -1);
      chk(rx_b[2] == pat(10'(a), 1'b1), "R5 long read", int'(rx_b[2]), int'(pat(10'(a), 1'b1)));
    end

    // R6 burst from buffer base
    set_long(10'h300, 1'b0, 4'h0);
    for (int k = 2; k < 7; k++) tx_b[k] = 8'h00;
    spi_run(7, -1);
    for (int k = 0; k < 5; k++)
      chk(rx_b[2+k] == pat(10'(10'h300 + k), 1'b1), "R6 buffer burst",
          int'(rx_b[2+k]), int'(pat(10'(10'h300 + k), 1'b1)));
    chk(re_n == 6 && re_a[5] == 10'h305, "R6 strobe addrs", int'(re_a[5]), 'h305);
    // R6 long wrap
    set_long(10'h3FE, 1'b0, 4'h0);
    spi_run(5, -1);
    for (int k = 0; k < 3; k++)
      chk(rx_b[2+k] == pat(10'((1022 + k) % 1024), 1'b1), "R6 long wrap",
          int'(rx_b[2+k]), int'(pat(10'((1022 + k) % 1024), 1'b1)));
    // R6 short wrap
    tx_b[0] = s_cmd(6'h3E, 1'b0);
    spi_run(4, -1);
    for (int k = 0; k < 3; k++)
      chk(rx_b[1+k] == pat(10'((62 + k) % 64), 1'b0), "R6 short wrap",
          int'(rx_b[1+k]), int'(pat(10'((62 + k) % 64), 1'b0)));
    // R10
    chk(miso == 1'b0, "R10 idle miso", int'(miso), 0);

    // R7 abort mid data byte
    tx_b[0] = s_cmd(6'h05, 1'b1);
    tx_b[1] = 8'hFF;
    spi_run(2, 13);
    chk(we_n == 0, "R7 partial data", we_n, 0);
    tx_b[0] = s_cmd(6'h07, 1'b1);
    tx_b[1] = 8'hC3;
    spi_run(2, -1);
    chk(we_n == 1 && we_a[0] == 10'h07 && we_d[0] == 8'hC3, "R7 resync data",
        {we_a[0], we_d[0]}, {10'h07, 8'hC3});
    // R7 abort mid command
    tx_b[0] = 8'hFF;
    spi_run(1, 3);
    chk(we_n == 0 && re_n == 0, "R7 partial cmd", we_n + re_n, 0);
    set_long(10'h123, 1'b1, 4'h9);
    tx_b[2] = 8'h99;
    spi_run(3, -1);
    chk(we_n == 1 && we_a[0] == 10'h123 && we_l[0] && we_d[0] == 8'h99, "R7 resync cmd",
        {we_a[0], we_d[0]}, {10'h123, 8'h99});

    // R9
    chk(dbl == 0, "R9 strobe pulses", dbl, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule